// File: doc/BRIEF.md
# Latched-Address Byte-Writable Static Memory

This block is a word-organised static memory of 18-bit words. The address and an active-low chip select enter through a pair of level-sensitive holding stages that share one open/close control. Write data enters through its own holding stage with a separate control. When a control is high, its stage passes the input straight through. When it is low, the stage keeps the value it last passed. With both controls tied high the block acts as a plain asynchronous memory. With them pulsed, a bus master can move on to the next address or data while the current access finishes.

The word is split into two 9-bit lanes, and each lane has its own active-low write strobe. An active-low output enable decides whether the block drives the shared data bus. The bus is exposed as separate in and out vectors plus a drive flag, so a pad ring can build the tri-state pin. Array updates are committed on the clock edge that closes a write cycle. Read data is combinational from the effective address, and any lane being written in the current cycle is forwarded to the output. Depth is 2**ADDR_W words. The full configuration uses ADDR_W = 16, which gives 65,536 words.

Top module: `latched_sram`

## Requirements
- R1: The array holds 2**ADDR_W words of 18 bits; a word written at an address is returned on dqOut when that address is later read.
- R2: While addrLatchEn is high the effective address follows addrIn; while it is low the effective address stays at the value present on the last clock edge at which addrLatchEn was high, for both reads and writes.
- R3: chipEnN is active low and is held by the same stage as the address: with addrLatchEn low, the held chip select, not the live chipEnN pin, governs drive and writes.
- R4: While dataLatchEn is high the write data follows dqIn; while it is low, writes use the value present on the last clock edge at which dataLatchEn was high.
- R5: With lowWrN low and upWrN high, only bits 8:0 of the addressed word are updated; bits 17:9 keep their value.
- R6: With upWrN low and lowWrN high, only bits 17:9 are updated; bits 8:0 keep their value.
- R7: With both strobes low, all 18 bits are updated; the update is in the array from the next clock edge onward.
- R8: No array update takes place while the effective chip select is high, whatever the strobes do.
- R9: dqOe is 1 exactly when the effective chip select is low, outEnN is low and both write strobes are high; otherwise the bus is released (dqOe 0).
- R10: During a write cycle dqOut shows the new write data in every lane being written and the stored contents in the other lane.
- R11: After reset the held chip select is deasserted, so with addrLatchEn low the block neither drives the bus nor writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; held values and array updates change on its rising edge |
| rstN | input | 1 | Active-low asynchronous reset of the holding stages |
| addrIn | input | ADDR_W | Word address |
| chipEnN | input | 1 | Active-low chip select, held with the address |
| addrLatchEn | input | 1 | High: address/select stage transparent; low: hold |
| dataLatchEn | input | 1 | High: write-data stage transparent; low: hold |
| lowWrN | input | 1 | Active-low write strobe for bits 8:0 |
| upWrN | input | 1 | Active-low write strobe for bits 17:9 |
| outEnN | input | 1 | Active-low output enable |
| dqIn | input | 18 | Data arriving from the shared bus pin |
| dqOut | output | 18 | Read data toward the shared bus pin |
| dqOe | output | 1 | Drive flag for the shared bus pin |

## Verification
Writes are driven with each strobe alone and with both together, using lane patterns whose halves differ. This separates a lane mix-up or a wrongly sized lane from a correct byte write. The holding stages are tested by changing addrIn, chipEnN and dqIn while their control is low and then reading other addresses with the stages open. This tells a stage that holds apart from one that leaks the live pin. Writes attempted under a deasserted select, whether live or held, and reads with a strobe or output enable inactive, show whether drive and update depend on the effective select rather than the pin.

// File: rtl/latched_sram_pkg.sv
package latched_sram_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic [LANES-1:0] wrLane;   // per-lane write commit request
    logic             drive;    // bus drive permitted
    logic             dataOpen; // write-data stage transparent
  } mem_strobe_t;
endpackage

// File: rtl/latched_sram_ctrl.sv
module latched_sram_ctrl
  import latched_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              chipEnN,
  input  logic              addrLatchEn,
  input  logic              dataLatchEn,
  input  logic [LANES-1:0]  wrN,
  input  logic              outEnN,
  output logic [ADDR_W-1:0] addrEff,
  output mem_strobe_t       stb
);
  logic [ADDR_W-1:0] heldAddr;
  logic              heldCeN;
  logic              ceEffN;
  logic [LANES-1:0]  laneReq;

  // Holding stage for address and chip select
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr <= '0;
      heldCeN  <= 1'b1;
    end else if (addrLatchEn) begin
      heldAddr <= addrIn;
      heldCeN  <= chipEnN;
    end
  end

  assign addrEff = addrLatchEn ? addrIn : heldAddr;
  assign ceEffN  = addrLatchEn ? chipEnN : heldCeN;
  assign laneReq = ~wrN;

  always_comb begin
    stb.wrLane   = ceEffN ? '0 : laneReq;
    stb.drive    = !ceEffN && !outEnN && (laneReq == '0);
    stb.dataOpen = dataLatchEn;
  end

  // R2: a closed stage keeps the effective address steady
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!addrLatchEn && $past(!addrLatchEn)) |-> (addrEff == $past(addrEff)))
    else $error("address moved while stage closed");

  // R3: a held, deasserted select blocks both writes and drive
  assert_held_ce_blocks_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!addrLatchEn && heldCeN) |-> (stb.wrLane == '0 && !stb.drive))
    else $error("held select ignored");
endmodule

// File: rtl/latched_sram_dp.sv
module latched_sram_dp
  import latched_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrEff,
  input  mem_strobe_t       stb,
  input  logic [DATA_W-1:0] dqIn,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [DATA_W-1:0] heldData;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] readWord;

  // Holding stage for write data
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             heldData <= '0;
    else if (stb.dataOpen) heldData <= dqIn;
  end

  assign wrData = stb.dataOpen ? dqIn : heldData;

  // Lane-masked array update
  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (stb.wrLane[l])
        memArr[addrEff][l*LANE_W +: LANE_W] <= wrData[l*LANE_W +: LANE_W];
    end
  end

  assign readWord = memArr[addrEff];

  // Per-lane forwarding of data being written this cycle
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dqOut[g*LANE_W +: LANE_W] = stb.wrLane[g] ?
      wrData[g*LANE_W +: LANE_W] : readWord[g*LANE_W +: LANE_W];

    // R5, R6: an unstrobed lane keeps its stored bits
    assert_lane_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
      !stb.wrLane[g] |=> (memArr[$past(addrEff)][g*LANE_W +: LANE_W] ==
                          $past(readWord[g*LANE_W +: LANE_W])))
      else $error("unstrobed lane changed");
  end

  assign dqOe = stb.drive;

  // R7: full strobe commits the whole write word
  assert_write_commit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrLane == '1) |=> (memArr[$past(addrEff)] == $past(wrData)))
    else $error("full write not committed");

  // R9: never drive while any lane is being written
  assert_no_drive_on_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.drive |-> (stb.wrLane == '0))
    else $error("bus driven during write");
endmodule

// File: rtl/latched_sram.sv
module latched_sram
  import latched_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              chipEnN,
  input  logic              addrLatchEn,
  input  logic              dataLatchEn,
  input  logic              lowWrN,
  input  logic              upWrN,
  input  logic              outEnN,
  input  logic [17:0]       dqIn,
  output logic [17:0]       dqOut,
  output logic              dqOe
);
  logic [ADDR_W-1:0] addrEff;
  mem_strobe_t       stb;

  latched_sram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .chipEnN(chipEnN),
    .addrLatchEn(addrLatchEn), .dataLatchEn(dataLatchEn),
    .wrN({upWrN, lowWrN}), .outEnN(outEnN),
    .addrEff(addrEff), .stb(stb)
  );

  latched_sram_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .addrEff(addrEff), .stb(stb),
    .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );
endmodule

// File: tb/latched_sram_bench.sv
`timescale 1ns/1ps
module latched_sram_bench;
  localparam int ADDR_W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic chipEnN = 1'b1, addrLatchEn = 1'b0, dataLatchEn = 1'b0;
  logic lowWrN = 1'b1, upWrN = 1'b1, outEnN = 1'b1;
  logic [17:0] dqIn = '0;
  logic [17:0] dqOut;
  logic dqOe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic        oe;
    bit          chkData;
    logic [17:0] data;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  always #10 clk = ~clk;  // 50 MHz

  latched_sram #(.ADDR_W(ADDR_W)) u_latched_sram (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .chipEnN(chipEnN),
    .addrLatchEn(addrLatchEn), .dataLatchEn(dataLatchEn),
    .lowWrN(lowWrN), .upWrN(upWrN), .outEnN(outEnN),
    .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );

  // Driver: one bus cycle per call, drives at the falling edge
  task automatic step(input logic [ADDR_W-1:0] a, input logic ce, input logic al,
                      input logic dl, input logic lw, input logic uw, input logic oe,
                      input logic [17:0] d, input logic expOe, input bit chk,
                      input logic [17:0] expData, input string tag);
    exp_t e;
    @(negedge clk);
    addrIn = a; chipEnN = ce; addrLatchEn = al; dataLatchEn = dl;
    lowWrN = lw; upWrN = uw; outEnN = oe; dqIn = d;
    e.oe = expOe; e.chkData = chk; e.data = expData; e.tag = tag;
    expQ.push_back(e);
  endtask

  // Monitor: samples mid-way between falling and rising edges
  initial begin
    forever begin
      @(negedge clk);
      #7;
      while (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (dqOe !== e.oe) begin
          errors++;
          $display("FAIL %s: dqOe actual %0b expected %0b", e.tag, dqOe, e.oe);
        end else if (e.chkData && dqOut !== e.data) begin
          errors++;
          $display("FAIL %s: dqOut actual %05h expected %05h", e.tag, dqOut, e.data);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [17:0] d1, d4, d5, d6, d7, e1, e2;
    d1 = 18'h2A5A5; d4 = 18'h12345; d5 = 18'h0F0F0;
    d6 = 18'h3C3C3; d7 = 18'h00FFF;
    e1 = {d1[17:9], 9'h1FF};
    e2 = {9'h000, e1[8:0]};

    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R11: held select deasserted after reset, live pin asserted
    step(0, 0, 0, 0, 1, 1, 0, 18'h0, 0, 0, 0, "R11");

    // R7/R10: full transparent write, forwarded data
    step(5, 0, 1, 1, 0, 0, 1, d1, 0, 1, d1, "R10");
    step(5, 0, 1, 1, 1, 1, 0, 0, 1, 1, d1, "R1");

    // R5: lower lane only
    step(5, 0, 1, 1, 0, 1, 1, 18'h3FFFF, 0, 1, e1, "R10");
    step(5, 0, 1, 1, 1, 1, 0, 0, 1, 1, e1, "R5");

    // R6: upper lane only
    step(5, 0, 1, 1, 1, 0, 1, 18'h00000, 0, 1, e2, "R10");
    step(5, 0, 1, 1, 1, 1, 0, 0, 1, 1, e2, "R6");

    // R7: full write elsewhere
    step(9, 0, 1, 1, 0, 0, 1, d4, 0, 1, d4, "R7");
    step(9, 0, 1, 1, 1, 1, 0, 0, 1, 1, d4, "R7");

    // R2: address stage holds 5 while addrIn moves to 9
    step(5, 0, 1, 1, 1, 1, 0, 0, 1, 1, e2, "R2");
    step(9, 0, 0, 1, 1, 1, 0, 0, 1, 1, e2, "R2");
    step(9, 0, 0, 1, 0, 0, 1, d5, 0, 1, d5, "R2");
    step(9, 0, 1, 1, 1, 1, 0, 0, 1, 1, d4, "R2");
    step(5, 0, 1, 1, 1, 1, 0, 0, 1, 1, d5, "R2");

    // R4: data stage holds d6 while dqIn moves to d7
    step(5, 0, 1, 1, 1, 1, 1, d6, 0, 1, d5, "R4");
    step(5, 0, 1, 0, 0, 0, 1, d7, 0, 1, d6, "R4");
    step(5, 0, 1, 1, 1, 1, 0, 0, 1, 1, d6, "R4");

    // R3: select held with address
    step(5, 0, 1, 1, 1, 1, 0, 0, 1, 1, d6, "R3");
    step(5, 1, 0, 1, 1, 1, 0, 0, 1, 1, d6, "R3");
    step(5, 1, 1, 1, 1, 1, 0, 0, 0, 0, 0, "R3");

    // R8: writes under held and live deasserted select
    step(5, 0, 0, 1, 0, 0, 1, d7, 0, 0, 0, "R8");
    step(5, 1, 1, 1, 0, 0, 1, d7, 0, 0, 0, "R8");
    step(5, 0, 1, 1, 1, 1, 0, 0, 1, 1, d6, "R8");

    // R9: output enable and strobe gate the drive
    step(5, 0, 1, 1, 1, 1, 1, 0, 0, 1, d6, "R9");
    step(5, 0, 1, 1, 1, 0, 0, d6, 0, 1, d6, "R9");
    step(5, 0, 1, 1, 1, 1, 0, 0, 1, 1, d6, "R9");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule